// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a CPU core and decides, at each instruction boundary, which interrupt the core should take. Peripheral sources each present a status flag and an enable bit; a source requests service only while both are set. Several serial-port sources fold into one shared interrupt number. Above all peripheral numbers sits a fixed tier: a software-interrupt request, an illegal-opcode request and a non-maskable external request, each latched from a one-cycle strobe.

When the core signals a boundary and no earlier decision is still outstanding, the controller picks a winner. It registers the interrupt number and the handler-vector address, and pulses an acceptance strobe with a command to set either the I or the X mask bit. The number and address stay put until the core acknowledges the vector fetch. Maskable numbers are ranked by a writable priority table that starts in identity order. A maskable interrupt is not consumed by acceptance, so it fires again while its device flag stays set.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `irq_valid`, `irq_take`, `set_i`, `set_x` are 0, `take_cnt` is 0, no fixed-tier request is latched and priority slot k holds number k.
- R2: Peripheral source s requests service only while `src_flag[s]` and `src_en[s]` are both 1; a set flag with a clear enable is never taken.
- R3: Sources 0 to 3 share interrupt number 0, which is pending while any of them is active; source s of 4 or more maps to number s-3.
- R4: The fixed tier ranks software interrupt (number 15) over illegal opcode (number 14) over the external request (number 13), and software and illegal-opcode requests are taken whatever the values of `ccr_i` and `ccr_x`.
- R5: A fixed-tier request is cleared when accepted, so it is taken once per strobe; a maskable number is not cleared and is taken again at the next boundary while its source stays active.
- R6: The external request is taken only when `ccr_x` is 0; while it is latched and `ccr_x` is 1, no interrupt of any kind is taken.
- R7: While `ccr_i` is 1 no maskable number (0 to 12) is taken.
- R8: Among pending maskable numbers the one held in the lowest priority slot wins; a write with `prio_we` stores `prio_num` into slot `prio_slot` (slots 0 to 8; other slot values are ignored) and takes effect from the next cycle.
- R9: While `irq_valid` is 1, `vec_addr` equals 0xFFC0 plus twice `irq_num`.
- R10: `irq_take` is a one-cycle pulse in the cycle after acceptance, together with `set_x` for number 13 and `set_i` for every other number.
- R11: A decision is made only on a cycle with `insn_bnd` high and `irq_valid` low; once made, `irq_valid`, `irq_num` and `vec_addr` hold until a cycle with `vec_ack` high, after which `irq_valid` falls.
- R12: `take_cnt` rises by one, modulo 2^16, on each acceptance and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_flag | input | 12 | Peripheral status flags |
| src_en | input | 12 | Peripheral enables, one per flag |
| ccr_i | input | 1 | CPU maskable-interrupt mask bit |
| ccr_x | input | 1 | CPU external-request mask bit |
| swi_req | input | 1 | Software-interrupt strobe |
| ill_req | input | 1 | Illegal-opcode strobe |
| xirq_req | input | 1 | External non-maskable request strobe |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| vec_ack | input | 1 | Core has fetched the vector |
| prio_we | input | 1 | Priority-table write enable |
| prio_slot | input | 4 | Priority-table slot to write |
| prio_num | input | 4 | Interrupt number stored in the slot |
| irq_take | output | 1 | Acceptance pulse |
| irq_valid | output | 1 | A decision is held for the core |
| irq_num | output | 4 | Accepted interrupt number |
| vec_addr | output | 16 | Address of the handler vector |
| set_i | output | 1 | Command to set the I bit |
| set_x | output | 1 | Command to set the X bit |
| take_cnt | output | 16 | Count of accepted interrupts |

## Verification
The bench goes after the external request latched while X is set: a design that lets a maskable number slip past it would show a take with set_i where none is due. It raises all three fixed-tier strobes at once under both masks, so a wrong ranking or a request that is not cleared on acceptance shows up as a wrong or repeated number. It keeps a serial flag set across two boundaries and drops one of two shared sources. A design that consumed maskable numbers, or that cleared a shared number when only one source went quiet, would miss the second take. Priority-table writes, boundaries while a decision is held and long random stretches catch a wrong order walk, a decision replaced before acknowledgement, or a mis-scaled vector address.

// File: rtl/irq_pkg.sv
// Shared helpers for the interrupt controller: how peripheral sources fold
// onto interrupt numbers and where the fixed-tier numbers sit.
// Assumes the shared sources occupy the lowest source indices.
package irq_pkg;

    // Interrupt number served by peripheral source src
    function automatic int src_to_num(int src, int shared);
        return (src < shared) ? 0 : src - shared + 1;
    endfunction

    function automatic int xirq_num(int n_irq);
        return n_irq - 3;
    endfunction

    function automatic int ill_num(int n_irq);
        return n_irq - 2;
    endfunction

    function automatic int swi_num(int n_irq);
        return n_irq - 1;
    endfunction

endpackage

// File: rtl/irq_src_collect.sv
// Folds peripheral flag/enable pairs into one pending bit per maskable
// interrupt number. A number is pending while any source mapped to it is
// both flagged and enabled. Assumes inputs are already synchronous.
module irq_src_collect
    import irq_pkg::*;
#(
    parameter int N_SRC    = 12,
    parameter int N_SHARED = 4,
    parameter int NMASK    = N_SRC - N_SHARED + 1
) (
    input  logic [N_SRC-1:0] src_flag,
    input  logic [N_SRC-1:0] src_en,
    output logic [NMASK-1:0] mpend
);

    // Sources that map onto number n
    function automatic logic [N_SRC-1:0] num_sources(int n);
        logic [N_SRC-1:0] m;
        m = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (src_to_num(s, N_SHARED) == n) m[s] = 1'b1;
        end
        return m;
    endfunction

    logic [N_SRC-1:0] active;
    assign active = src_flag & src_en;

    genvar n;
    generate
        for (n = 0; n < NMASK; n++) begin : g_num
            localparam logic [N_SRC-1:0] SEL = num_sources(n);
            // Number n pending when any of its sources is active
            assign mpend[n] = |(active & SEL);
        end
    endgenerate

endmodule

// File: rtl/irq_prio_table.sv
// Writable ranking of the maskable interrupt numbers. Slot 0 is the
// highest rank. Resets to identity order. Writes to slots beyond the
// table are dropped; a write is visible from the following cycle.
module irq_prio_table #(
    parameter int NMASK  = 9,
    parameter int NUM_W  = 4,
    parameter int SLOT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prio_we,
    input  logic [SLOT_W-1:0]      prio_slot,
    input  logic [NUM_W-1:0]       prio_num,
    output logic [NMASK*NUM_W-1:0] order_flat
);

    genvar k;
    generate
        for (k = 0; k < NMASK; k++) begin : g_slot
            logic [NUM_W-1:0] entry;
            // Slot k: identity on reset, loaded when addressed by a write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    entry <= NUM_W'(k);
                else if (prio_we && prio_slot == SLOT_W'(k))
                    entry <= prio_num;
            end
            assign order_flat[k*NUM_W +: NUM_W] = entry;
        end
    endgenerate

endmodule

// File: rtl/irq_select.sv
// Purely combinational choice of the winning interrupt. Fixed tier first
// (software, illegal opcode, external request gated by X); a latched
// external request under X blocks everything. Otherwise, with I clear,
// the first table slot whose number is pending wins.
// Assumes NMASK does not exceed the external-request number.
module irq_select
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int NMASK   = 9,
    parameter int NUM_W   = 4
) (
    input  logic [NMASK-1:0]       mpend,
    input  logic [NMASK*NUM_W-1:0] order_flat,
    input  logic                   swi_pend,
    input  logic                   ill_pend,
    input  logic                   xirq_pend,
    input  logic                   ccr_i,
    input  logic                   ccr_x,
    output logic                   found,
    output logic [NUM_W-1:0]       win_num
);

    localparam logic [NUM_W-1:0] SWI_N  = NUM_W'(swi_num(NUM_IRQ));
    localparam logic [NUM_W-1:0] ILL_N  = NUM_W'(ill_num(NUM_IRQ));
    localparam logic [NUM_W-1:0] XIRQ_N = NUM_W'(xirq_num(NUM_IRQ));

    logic [NUM_IRQ-1:0] mpad;
    assign mpad = NUM_IRQ'(mpend);

    // Tiered decision, table walked from the lowest rank upward
    always_comb begin
        found   = 1'b0;
        win_num = '0;
        if (swi_pend) begin
            found   = 1'b1;
            win_num = SWI_N;
        end else if (ill_pend) begin
            found   = 1'b1;
            win_num = ILL_N;
        end else if (xirq_pend) begin
            if (!ccr_x) begin
                found   = 1'b1;
                win_num = XIRQ_N;
            end
        end else if (!ccr_i) begin
            for (int k = NMASK - 1; k >= 0; k--) begin
                if (mpad[order_flat[k*NUM_W +: NUM_W]]) begin
                    found   = 1'b1;
                    win_num = order_flat[k*NUM_W +: NUM_W];
                end
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Interrupt controller top. Latches fixed-tier strobes, arbitrates on an
// instruction boundary when nothing is held, and holds number and vector
// address until the core acknowledges. Emits the mask-bit command and
// counts acceptances. Assumes the core keeps ccr_i/ccr_x current.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int          N_SRC    = 12,
    parameter int          N_SHARED = 4,
    parameter int          NUM_IRQ  = 16,
    parameter int          CNT_W    = 16,
    parameter logic [15:0] VEC_BASE = 16'hFFC0,
    localparam int         NMASK    = N_SRC - N_SHARED + 1,
    localparam int         NUM_W    = $clog2(NUM_IRQ),
    localparam int         SLOT_W   = $clog2(NMASK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_flag,
    input  logic [N_SRC-1:0]  src_en,
    input  logic              ccr_i,
    input  logic              ccr_x,
    input  logic              swi_req,
    input  logic              ill_req,
    input  logic              xirq_req,
    input  logic              insn_bnd,
    input  logic              vec_ack,
    input  logic              prio_we,
    input  logic [SLOT_W-1:0] prio_slot,
    input  logic [NUM_W-1:0]  prio_num,
    output logic              irq_take,
    output logic              irq_valid,
    output logic [NUM_W-1:0]  irq_num,
    output logic [15:0]       vec_addr,
    output logic              set_i,
    output logic              set_x,
    output logic [CNT_W-1:0]  take_cnt
);

    localparam logic [NUM_W-1:0] SWI_N  = NUM_W'(swi_num(NUM_IRQ));
    localparam logic [NUM_W-1:0] ILL_N  = NUM_W'(ill_num(NUM_IRQ));
    localparam logic [NUM_W-1:0] XIRQ_N = NUM_W'(xirq_num(NUM_IRQ));

    logic [NMASK-1:0]       mpend;
    logic [NMASK*NUM_W-1:0] order_flat;
    logic                   swi_pend, ill_pend, xirq_pend;
    logic                   found;
    logic [NUM_W-1:0]       win_num;
    logic                   accept;

    irq_src_collect #(.N_SRC(N_SRC), .N_SHARED(N_SHARED), .NMASK(NMASK)) u_collect (
        .src_flag (src_flag),
        .src_en   (src_en),
        .mpend    (mpend)
    );

    irq_prio_table #(.NMASK(NMASK), .NUM_W(NUM_W), .SLOT_W(SLOT_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we    (prio_we),
        .prio_slot  (prio_slot),
        .prio_num   (prio_num),
        .order_flat (order_flat)
    );

    irq_select #(.NUM_IRQ(NUM_IRQ), .NMASK(NMASK), .NUM_W(NUM_W)) u_select (
        .mpend      (mpend),
        .order_flat (order_flat),
        .swi_pend   (swi_pend),
        .ill_pend   (ill_pend),
        .xirq_pend  (xirq_pend),
        .ccr_i      (ccr_i),
        .ccr_x      (ccr_x),
        .found      (found),
        .win_num    (win_num)
    );

    assign accept = !irq_valid && insn_bnd && found;

    // Fixed-tier latches: clear on own acceptance, then apply new strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swi_pend  <= 1'b0;
            ill_pend  <= 1'b0;
            xirq_pend <= 1'b0;
        end else begin
            swi_pend  <= (swi_pend  && !(accept && win_num == SWI_N))  || swi_req;
            ill_pend  <= (ill_pend  && !(accept && win_num == ILL_N))  || ill_req;
            xirq_pend <= (xirq_pend && !(accept && win_num == XIRQ_N)) || xirq_req;
        end
    end

    // Decision register: load on acceptance, release on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_num   <= '0;
            vec_addr  <= VEC_BASE;
        end else if (irq_valid) begin
            if (vec_ack) irq_valid <= 1'b0;
        end else if (accept) begin
            irq_valid <= 1'b1;
            irq_num   <= win_num;
            vec_addr  <= VEC_BASE + {{(15 - NUM_W){1'b0}}, win_num, 1'b0};
        end
    end

    // Acceptance pulse, mask command and running count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take <= 1'b0;
            set_i    <= 1'b0;
            set_x    <= 1'b0;
            take_cnt <= '0;
        end else begin
            irq_take <= accept;
            set_x    <= accept && win_num == XIRQ_N;
            set_i    <= accept && win_num != XIRQ_N;
            if (accept) take_cnt <= take_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/irq_arbiter_chk.sv
// Port-level checker for irq_arbiter, attached by bind below.
// Assumes at least two reset cycles before release.
module irq_arbiter_chk #(
    parameter int          NUM_IRQ  = 16,
    parameter int          CNT_W    = 16,
    parameter logic [15:0] VEC_BASE = 16'hFFC0,
    localparam int         NUM_W    = $clog2(NUM_IRQ)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ccr_i,
    input logic             ccr_x,
    input logic             insn_bnd,
    input logic             vec_ack,
    input logic             irq_take,
    input logic             irq_valid,
    input logic [NUM_W-1:0] irq_num,
    input logic [15:0]      vec_addr,
    input logic             set_i,
    input logic             set_x,
    input logic [CNT_W-1:0] take_cnt
);

    localparam logic [NUM_W-1:0] XIRQ_N = NUM_W'(NUM_IRQ - 3);

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !vec_ack) |=> (irq_valid && $stable(irq_num) && $stable(vec_addr)));

    p_take_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(insn_bnd) && !$past(irq_valid) && irq_valid));

    p_vec_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (vec_addr == VEC_BASE + 16'(2 * int'(irq_num))));

    p_mask_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (set_x == (irq_num == XIRQ_N)) && (set_i == (irq_num != XIRQ_N)));

    p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_i, set_x}) && ((set_i || set_x) == irq_take));

    p_count_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (take_cnt == $past(take_cnt) + CNT_W'(1)));

    p_imask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && $past(ccr_i)) |-> (irq_num >= XIRQ_N));

    p_xmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && $past(ccr_x)) |-> (irq_num != XIRQ_N));

endmodule

bind irq_arbiter irq_arbiter_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .CNT_W    (CNT_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ccr_i     (ccr_i),
    .ccr_x     (ccr_x),
    .insn_bnd  (insn_bnd),
    .vec_ack   (vec_ack),
    .irq_take  (irq_take),
    .irq_valid (irq_valid),
    .irq_num   (irq_num),
    .vec_addr  (vec_addr),
    .set_i     (set_i),
    .set_x     (set_x),
    .take_cnt  (take_cnt)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, compared with the outputs every clock.
module irq_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_flag = '0;
    logic [11:0] src_en = '0;
    logic        ccr_i = 1'b0, ccr_x = 1'b0;
    logic        swi_req = 1'b0, ill_req = 1'b0, xirq_req = 1'b0;
    logic        insn_bnd = 1'b0, vec_ack = 1'b0;
    logic        prio_we = 1'b0;
    logic [3:0]  prio_slot = '0, prio_num = '0;
    logic        irq_take, irq_valid, set_i, set_x;
    logic [3:0]  irq_num;
    logic [15:0] vec_addr, take_cnt;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_order [9];
    bit m_swp, m_ilp, m_xp, m_valid, m_take, m_si, m_sx;
    int m_num, m_cnt, m_win;
    bit [15:0] m_pend;

    always #2 clk = ~clk;

    irq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
        .ccr_i(ccr_i), .ccr_x(ccr_x), .swi_req(swi_req), .ill_req(ill_req),
        .xirq_req(xirq_req), .insn_bnd(insn_bnd), .vec_ack(vec_ack),
        .prio_we(prio_we), .prio_slot(prio_slot), .prio_num(prio_num),
        .irq_take(irq_take), .irq_valid(irq_valid), .irq_num(irq_num),
        .vec_addr(vec_addr), .set_i(set_i), .set_x(set_x), .take_cnt(take_cnt)
    );

    // model: next state from inputs as seen at this edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_swp = 0; m_ilp = 0; m_xp = 0; m_valid = 0;
            m_take = 0; m_si = 0; m_sx = 0; m_cnt = 0; m_num = 0;
            for (int k = 0; k < 9; k++) m_order[k] = k;
        end else begin
            m_pend = '0;
            for (int s = 0; s < 12; s++)
                if (src_flag[s] && src_en[s]) m_pend[(s < 4) ? 0 : s - 3] = 1'b1;
            m_win = -1;
            if (m_swp) m_win = 15;
            else if (m_ilp) m_win = 14;
            else if (m_xp) begin
                if (!ccr_x) m_win = 13;
            end else if (!ccr_i) begin
                for (int k = 0; k < 9; k++)
                    if (m_win < 0 && m_pend[m_order[k]]) m_win = m_order[k];
            end
            m_take = 0; m_si = 0; m_sx = 0;
            if (m_valid) begin
                if (vec_ack) m_valid = 0;
            end else if (insn_bnd && m_win >= 0) begin
                m_valid = 1; m_num = m_win; m_take = 1;
                m_sx = (m_win == 13); m_si = !m_sx;
                m_cnt = (m_cnt + 1) % 65536;
                if (m_win == 15) m_swp = 0;
                if (m_win == 14) m_ilp = 0;
                if (m_win == 13) m_xp = 0;
            end
            m_swp = m_swp | swi_req;
            m_ilp = m_ilp | ill_req;
            m_xp  = m_xp  | xirq_req;
            if (prio_we && prio_slot < 9) m_order[prio_slot] = int'(prio_num);
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            cmp("irq_valid", int'(irq_valid), int'(m_valid));
            cmp("irq_take",  int'(irq_take),  int'(m_take));
            cmp("set_i",     int'(set_i),     int'(m_si));
            cmp("set_x",     int'(set_x),     int'(m_sx));
            cmp("take_cnt",  int'(take_cnt),  m_cnt);
            if (m_valid) begin
                cmp("irq_num",  int'(irq_num),  m_num);
                cmp("vec_addr", int'(vec_addr), 16'hFFC0 + 2 * m_num);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // boundary, wait, acknowledge
    task automatic arb();
        insn_bnd = 1'b1; tick(1); insn_bnd = 1'b0;
        tick(2);
        vec_ack = 1'b1; tick(1); vec_ack = 1'b0;
        tick(1);
    endtask

    task automatic strobe(int which);
        if (which == 0) swi_req = 1'b1;
        if (which == 1) ill_req = 1'b1;
        if (which == 2) xirq_req = 1'b1;
        tick(1);
        swi_req = 1'b0; ill_req = 1'b0; xirq_req = 1'b0;
    endtask

    task automatic wr_prio(int slot, int num);
        prio_we = 1'b1; prio_slot = 4'(slot); prio_num = 4'(num);
        tick(1);
        prio_we = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset state observed on the first cycles
        cur_req = "R1"; tick(2);
        arb();                                  // nothing pending: no take

        // R2: flag without enable is ignored, then enabled -> number 2
        cur_req = "R2";
        src_flag[5] = 1'b1; arb();
        src_en[5] = 1'b1; arb();
        src_flag = '0; src_en = '0; tick(1);

        // R3: shared serial sources fold onto number 0
        cur_req = "R3";
        src_en[3:0] = 4'hF; src_flag[1] = 1'b1; src_flag[3] = 1'b1; arb();
        src_flag[1] = 1'b0; arb();               // still pending via source 3
        src_flag = '0; src_en = '0; tick(1);

        // R7: I set blocks maskable
        cur_req = "R7";
        ccr_i = 1'b1; src_flag[8] = 1'b1; src_en[8] = 1'b1; arb();

        // R4: fixed tier order and independence from I/X
        cur_req = "R4";
        ccr_x = 1'b1;
        swi_req = 1'b1; ill_req = 1'b1; xirq_req = 1'b1; tick(1);
        swi_req = 1'b0; ill_req = 1'b0; xirq_req = 1'b0;
        arb(); arb();

        // R6: latched external request under X blocks all, then taken
        cur_req = "R6";
        ccr_i = 1'b0; arb(); arb();
        ccr_x = 1'b0; arb();

        // R5: fixed request taken once; maskable retaken while flagged
        cur_req = "R5";
        arb(); arb();
        strobe(0); arb(); arb();
        src_flag = '0; src_en = '0; tick(1);

        // R8: reprogram priority so number 6 outranks number 2
        cur_req = "R8";
        src_en = 12'hFFF; src_flag[5] = 1'b1; src_flag[9] = 1'b1; arb();
        wr_prio(0, 6); wr_prio(6, 0); arb();
        wr_prio(12, 2); arb();                    // slot out of range ignored
        src_flag = '0; src_en = '0; tick(1);

        // R11: boundaries while a decision is held are ignored
        cur_req = "R11";
        src_en[4] = 1'b1; src_flag[4] = 1'b1;
        insn_bnd = 1'b1; tick(1);
        strobe(0); tick(3); insn_bnd = 1'b0;
        vec_ack = 1'b1; tick(1); vec_ack = 1'b0; tick(1);
        arb();

        // R9 R10 R12: random traffic checked against the model
        cur_req = "R12";
        for (int c = 0; c < 4000; c++) begin
            src_flag = 12'($urandom);
            src_en   = 12'($urandom);
            ccr_i    = ($urandom % 3) == 0;
            ccr_x    = ($urandom % 4) == 0;
            swi_req  = ($urandom % 40) == 0;
            ill_req  = ($urandom % 40) == 0;
            xirq_req = ($urandom % 30) == 0;
            insn_bnd = ($urandom % 2) == 0;
            vec_ack  = ($urandom % 3) == 0;
            prio_we  = ($urandom % 25) == 0;
            prio_slot = 4'($urandom);
            prio_num  = 4'($urandom % 10);
            tick(1);
        end
        swi_req = 0; ill_req = 0; xirq_req = 0; prio_we = 0; insn_bnd = 0;
        tick(4);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule